// File: doc/BRIEF.md
# Predicated contiguous vector load sequencer

This block carries out one masked, contiguous load of unsigned 32-bit words into a vector result. A command gives a 32-bit instruction word, a general-register base value, a stack-pointer value, a 64-bit scalar index and a byte-granular predicate. The block checks the operand fields and takes the base from the stack pointer or the general register. It forms the start address as base plus four times the index. It then visits the element slots in order through a single-outstanding memory read port.

Active elements receive the loaded word zero-extended to the selected element width of 32, 64 or 128 bits. Inactive elements are filled with zero and never touch memory. The running address moves on by four bytes per slot whether the slot is active or not. When the last slot is finished, the assembled vector is committed to the result register together with a one-cycle completion pulse and the destination field. A malformed command or a misaligned stack-pointer base produces a one-cycle error pulse in place of the completion pulse, and no memory traffic.

Top module: `pcl_contig_load`

## Requirements
- R1: A command is accepted only when bits 31..23 equal 101001010 and the element class is one of: bits 22..21 = 10 with bits 15..13 = 010 (32-bit elements), bits 22..21 = 11 with bits 15..13 = 010 (64-bit), or bits 22..21 = 00 with bits 15..13 = 100 (128-bit).
- R2: A command whose pattern fails R1, or whose index field (bits 20..16) equals 31, produces a one-cycle `illegal_o` pulse, no memory request and no `done_o`.
- R3: The first slot address is base + 4*index modulo 2^64. The base is `cmd_sp_i` when the base field (bits 9..5) equals 31, and `cmd_gpr_i` otherwise.
- R4: Slot e uses address start + 4*e, and the address advances for inactive slots as well.
- R5: An inactive element causes no memory request and reads as all zeros in the result.
- R6: An active element e holds the returned 32-bit word zero-extended to the element width, at result bits [e*ES +: ES].
- R7: Element e is active exactly when predicate bit e*ES/8 is set. The other predicate bits of its group have no effect.
- R8: The element count is VLEN/ES: 8, 4 or 2 slots for the default VLEN of 256.
- R9: At most one read is outstanding. Each request lasts one cycle, and no new request is made until `mem_rvalid_i` returns data.
- R10: `res_data_o` and `res_dst_o` change only together with a one-cycle `done_o`. `res_dst_o` carries bits 4..0 of the command. At most one of `done_o`, `illegal_o` and `sp_fault_o` is high in any cycle, and all outputs are zero after reset.
- R11: With a stack-pointer base whose low 4 bits are not all zero, the command ends in a one-cycle `sp_fault_o` with no access. When no element is active and SKIP_SP_CHECK_IDLE=1 (the default), the check is skipped and the command completes with an all-zero result.
- R12: `cmd_valid_i` is ignored while `busy_o` is high.
- R13: For fixed memory latencies, the number of cycles from command to completion depends only on the predicate and not on the loaded data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid_i | input | 1 | Command strobe, taken while idle |
| cmd_insn_i | input | 32 | Instruction word carrying class and operand fields |
| cmd_gpr_i | input | AW | General-register base value |
| cmd_sp_i | input | AW | Stack-pointer base value |
| cmd_index_i | input | AW | Scalar word index |
| cmd_pred_i | input | VLEN/8 | Byte-granular predicate |
| busy_o | output | 1 | Sequence in progress |
| mem_req_o | output | 1 | One-cycle read request |
| mem_addr_o | output | AW | Read byte address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data word |
| done_o | output | 1 | Completion pulse |
| illegal_o | output | 1 | Rejected-encoding pulse |
| sp_fault_o | output | 1 | Stack-pointer misalignment pulse |
| res_data_o | output | VLEN | Committed vector result |
| res_dst_o | output | 5 | Destination field of the committed result |

## Verification
The hardest case to reach from the ports is a misaligned stack-pointer base in which no element is active at the chosen width, while the predicate still has bits set inside the element groups. The stimulus builds a 64-bit command whose predicate sets only the non-leading bits of each group, so the skip must follow the element activity and not a plain OR of the predicate. The second hard case is a command that arrives while the block is busy. The bench issues a long, fully active load and strobes an illegal command into the middle of it. The scoreboard then flags any extra outcome pulse, any unexpected memory request, or any change to the result.

// File: rtl/pcl_pkg.sv
package pcl_pkg;

   typedef enum logic [1:0] {
      ESZ_32  = 2'd0,
      ESZ_64  = 2'd1,
      ESZ_128 = 2'd2
   } esz_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SLOT = 2'd1,
      ST_WAIT = 2'd2
   } st_e;

   typedef struct packed {
      logic       match;
      logic       idx_bad;
      logic       base_sp;
      esz_e       esz;
      logic [4:0] dst;
   } dec_t;

endpackage

// File: rtl/pcl_decode.sv
module pcl_decode
   import pcl_pkg::*;
(
   input  logic [31:0] insn_i,
   output dec_t        dec_o
);
   localparam logic [8:0] PREFIX = 9'b101001010;

   logic unused_pg;
   assign unused_pg = ^insn_i[12:10];

   always_comb begin
      dec_o         = '0;
      dec_o.esz     = ESZ_32;
      dec_o.idx_bad = (insn_i[20:16] == 5'd31);
      dec_o.base_sp = (insn_i[9:5] == 5'd31);
      dec_o.dst     = insn_i[4:0];
      if (insn_i[31:23] == PREFIX) begin
         unique case (insn_i[22:21])
            2'b10: begin
               dec_o.match = (insn_i[15:13] == 3'b010);
               dec_o.esz   = ESZ_32;
            end
            2'b11: begin
               dec_o.match = (insn_i[15:13] == 3'b010);
               dec_o.esz   = ESZ_64;
            end
            2'b00: begin
               dec_o.match = (insn_i[15:13] == 3'b100);
               dec_o.esz   = ESZ_128;
            end
            default: dec_o.match = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/pcl_lane_mask.sv
module pcl_lane_mask
   import pcl_pkg::*;
#(
   parameter int VLEN = 256
) (
   input  logic [VLEN/8-1:0]  pred_i,
   input  esz_e               esz_i,
   output logic [VLEN/32-1:0] act_o
);
   localparam int NE = VLEN / 32;

   logic [NE-1:0] a32, a64, a128;
   logic          unused_pred;
   assign unused_pred = ^pred_i;

   for (genvar e = 0; e < NE; e++) begin : g_el
      assign a32[e] = pred_i[e*4];
      if (e < NE/2) begin : g_w64
         assign a64[e] = pred_i[e*8];
      end else begin : g_w64_off
         assign a64[e] = 1'b0;
      end
      if (e < NE/4) begin : g_w128
         assign a128[e] = pred_i[e*16];
      end else begin : g_w128_off
         assign a128[e] = 1'b0;
      end
   end

   always_comb begin
      unique case (esz_i)
         ESZ_64:  act_o = a64;
         ESZ_128: act_o = a128;
         default: act_o = a32;
      endcase
   end
endmodule

// File: rtl/pcl_elem_merge.sv
module pcl_elem_merge #(
   parameter int VLEN = 256,
   parameter int CW   = 3
) (
   input  logic [VLEN-1:0] work_i,
   input  logic [CW-1:0]   chunk_i,
   input  logic [31:0]     word_i,
   output logic [VLEN-1:0] merged_o
);
   localparam int NCH = VLEN / 32;

   for (genvar k = 0; k < NCH; k++) begin : g_chunk
      assign merged_o[k*32 +: 32] = (chunk_i == CW'(k)) ? word_i : work_i[k*32 +: 32];
   end
endmodule

// File: rtl/pcl_contig_load.sv
module pcl_contig_load
   import pcl_pkg::*;
#(
   parameter int VLEN               = 256,
   parameter int AW                 = 64,
   parameter int SP_ALIGN_BITS      = 4,
   parameter bit SKIP_SP_CHECK_IDLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid_i,
   input  logic [31:0]       cmd_insn_i,
   input  logic [AW-1:0]     cmd_gpr_i,
   input  logic [AW-1:0]     cmd_sp_i,
   input  logic [AW-1:0]     cmd_index_i,
   input  logic [VLEN/8-1:0] cmd_pred_i,
   output logic              busy_o,
   output logic              mem_req_o,
   output logic [AW-1:0]     mem_addr_o,
   input  logic              mem_rvalid_i,
   input  logic [31:0]       mem_rdata_i,
   output logic              done_o,
   output logic              illegal_o,
   output logic              sp_fault_o,
   output logic [VLEN-1:0]   res_data_o,
   output logic [4:0]        res_dst_o
);
   localparam int NE_MAX = VLEN / 32;
   localparam int CW     = $clog2(NE_MAX);
   localparam logic [CW:0] NE_W = (CW+1)'(NE_MAX);

   if (VLEN < 128 || (VLEN & (VLEN - 1)) != 0) begin : g_bad_vlen
      $error("pcl_contig_load: VLEN must be a power of two of at least 128");
   end
   if (AW < 32 || SP_ALIGN_BITS < 1 || SP_ALIGN_BITS >= AW) begin : g_bad_aw
      $error("pcl_contig_load: address width or alignment out of range");
   end

   // command decode and lane activity
   dec_t                dec;
   logic [NE_MAX-1:0]   act_now;
   logic                any_act;
   logic [AW-1:0]       base_sel;
   logic [AW-1:0]       start_addr;
   logic                sp_misal;

   pcl_decode u_dec (
      .insn_i (cmd_insn_i),
      .dec_o  (dec)
   );

   pcl_lane_mask #(.VLEN(VLEN)) u_mask (
      .pred_i (cmd_pred_i),
      .esz_i  (dec.esz),
      .act_o  (act_now)
   );

   assign any_act    = |act_now;
   assign base_sel   = dec.base_sp ? cmd_sp_i : cmd_gpr_i;
   assign start_addr = base_sel + (cmd_index_i << 2);
   assign sp_misal   = |cmd_sp_i[SP_ALIGN_BITS-1:0];

   // sequencing state
   st_e               st_q;
   logic [AW-1:0]     addr_q;
   logic [NE_MAX-1:0] act_q;
   esz_e              esz_q;
   logic [CW-1:0]     elem_q;
   logic [VLEN-1:0]   work_q;
   logic [4:0]        dst_q;
   logic              done_q, ill_q, flt_q;
   logic [VLEN-1:0]   res_q;
   logic [4:0]        res_dst_q;

   logic [CW-1:0]     chunk;
   logic [VLEN-1:0]   merged;
   logic [VLEN-1:0]   work_nxt;
   logic              last_slot;
   logic              step;
   logic              sp_skip;

   assign chunk     = CW'(elem_q << esz_q);
   assign last_slot = ({1'b0, elem_q} == ((NE_W >> esz_q) - 1'b1));
   assign step      = ((st_q == ST_SLOT) && !act_q[elem_q]) ||
                      ((st_q == ST_WAIT) && mem_rvalid_i);
   assign work_nxt  = (st_q == ST_WAIT) ? merged : work_q;

   if (SKIP_SP_CHECK_IDLE) begin : g_skip_idle
      assign sp_skip = !any_act;
   end else begin : g_check_always
      assign sp_skip = 1'b0;
   end

   pcl_elem_merge #(.VLEN(VLEN), .CW(CW)) u_merge (
      .work_i   (work_q),
      .chunk_i  (chunk),
      .word_i   (mem_rdata_i),
      .merged_o (merged)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         addr_q    <= '0;
         act_q     <= '0;
         esz_q     <= ESZ_32;
         elem_q    <= '0;
         work_q    <= '0;
         dst_q     <= '0;
         done_q    <= 1'b0;
         ill_q     <= 1'b0;
         flt_q     <= 1'b0;
         res_q     <= '0;
         res_dst_q <= '0;
      end else begin
         done_q <= 1'b0;
         ill_q  <= 1'b0;
         flt_q  <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (cmd_valid_i) begin
                  if (!dec.match || dec.idx_bad) begin
                     ill_q <= 1'b1;
                  end else if (dec.base_sp && sp_misal && !sp_skip) begin
                     flt_q <= 1'b1;
                  end else begin
                     addr_q <= start_addr;
                     act_q  <= act_now;
                     esz_q  <= dec.esz;
                     elem_q <= '0;
                     work_q <= '0;
                     dst_q  <= dec.dst;
                     st_q   <= ST_SLOT;
                  end
               end
            end
            ST_SLOT: begin
               if (act_q[elem_q]) st_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (mem_rvalid_i) work_q <= merged;
            end
            default: st_q <= ST_IDLE;
         endcase

         if (step) begin
            if (last_slot) begin
               st_q      <= ST_IDLE;
               done_q    <= 1'b1;
               res_q     <= work_nxt;
               res_dst_q <= dst_q;
            end else begin
               st_q   <= ST_SLOT;
               elem_q <= elem_q + 1'b1;
               addr_q <= addr_q + AW'(4);
            end
         end
      end
   end

   assign busy_o     = (st_q != ST_IDLE);
   assign mem_req_o  = (st_q == ST_SLOT) && act_q[elem_q];
   assign mem_addr_o = addr_q;
   assign done_o     = done_q;
   assign illegal_o  = ill_q;
   assign sp_fault_o = flt_q;
   assign res_data_o = res_q;
   assign res_dst_o  = res_dst_q;

endmodule

// File: rtl/pcl_checker.sv
module pcl_checker #(
   parameter int VLEN = 256
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cmd_valid_i,
   input logic            busy_o,
   input logic            mem_req_o,
   input logic            mem_rvalid_i,
   input logic            done_o,
   input logic            illegal_o,
   input logic            sp_fault_o,
   input logic [VLEN-1:0] res_data_o,
   input logic [4:0]      res_dst_o
);
   logic unused_rv;
   assign unused_rv = mem_rvalid_i;

   assert_single_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |=> !mem_req_o);

   assert_req_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> busy_o);

   assert_pulse_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done_o, illegal_o, sp_fault_o}));

   assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   assert_res_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(res_data_o) && $stable(res_dst_o)));

   assert_ill_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> ($past(cmd_valid_i) && !busy_o));

   assert_fault_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
      sp_fault_o |-> ($past(cmd_valid_i) && !busy_o));

endmodule

bind pcl_contig_load pcl_checker #(.VLEN(VLEN)) u_pcl_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmd_valid_i  (cmd_valid_i),
   .busy_o       (busy_o),
   .mem_req_o    (mem_req_o),
   .mem_rvalid_i (mem_rvalid_i),
   .done_o       (done_o),
   .illegal_o    (illegal_o),
   .sp_fault_o   (sp_fault_o),
   .res_data_o   (res_data_o),
   .res_dst_o    (res_dst_o)
);

// File: tb/pcl_contig_load_tb_top.sv
module pcl_contig_load_tb_top;
   localparam int VLEN = 256;
   localparam int PW   = VLEN / 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cmd_valid_i = 1'b0;
   logic [31:0]     cmd_insn_i = '0;
   logic [63:0]     cmd_gpr_i = '0, cmd_sp_i = '0, cmd_index_i = '0;
   logic [PW-1:0]   cmd_pred_i = '0;
   logic            busy_o, mem_req_o, done_o, illegal_o, sp_fault_o;
   logic [63:0]     mem_addr_o;
   logic            mem_rvalid_i = 1'b0;
   logic [31:0]     mem_rdata_i = '0;
   logic [VLEN-1:0] res_data_o;
   logic [4:0]      res_dst_o;

   always #5 clk = ~clk;

   pcl_contig_load #(.VLEN(VLEN)) dut_i (.*);

   typedef struct {
      int              kind;  // 0 done, 1 illegal, 2 sp fault
      logic [VLEN-1:0] res;
      logic [4:0]      dst;
      string           tag;
   } exp_t;

   exp_t        exp_q[$];
   logic [63:0] exp_addr_q[$];
   int          total = 0, bad = 0, outcome_cnt = 0, last_cycles = 0;
   logic [31:0] mem_seed = 32'h1357_9BDF;
   logic [VLEN-1:0] last_res = '0;

   function automatic logic [31:0] dfun(logic [63:0] a, logic [31:0] s);
      return (a[31:0] * 32'h045D_9F3B) ^ s ^ a[63:32];
   endfunction

   function automatic logic [31:0] mk(int es, logic [4:0] rm, logic [4:0] rn, logic [4:0] zt);
      logic [1:0] cls = (es == 32) ? 2'b10 : (es == 64) ? 2'b11 : 2'b00;
      logic [2:0] mid = (es == 128) ? 3'b100 : 3'b010;
      return {9'b101001010, cls, rm, mid, 3'd3, rn, zt};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // memory model: checks every request against the expected address list
   initial begin
      forever begin
         @(negedge clk);
         mem_rvalid_i = 1'b0;
         if (mem_req_o) begin
            logic [63:0] a;
            a = mem_addr_o;
            if (exp_addr_q.size() == 0) begin
               chk(1'b0, "R5 unexpected memory request", VLEN'(a), '0);
            end else begin
               logic [63:0] e;
               e = exp_addr_q.pop_front();
               chk(a == e, "R4 request address", VLEN'(a), VLEN'(e));
            end
            repeat (int'(a[3:2])) @(negedge clk);
            @(negedge clk);
            mem_rvalid_i = 1'b1;
            mem_rdata_i  = dfun(a, mem_seed);
         end
      end
   end

   // monitor / scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (done_o || illegal_o || sp_fault_o) begin
            int k;
            k = done_o ? 0 : (illegal_o ? 1 : 2);
            outcome_cnt++;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R12 outcome with no command pending", VLEN'(k), '0);
            end else begin
               exp_t x;
               x = exp_q.pop_front();
               chk(k == x.kind, {x.tag, " outcome kind"}, VLEN'(k), VLEN'(x.kind));
               if (x.kind == 0) begin
                  chk(res_data_o == x.res, {x.tag, " result"}, res_data_o, x.res);
                  chk(res_dst_o == x.dst, {x.tag, " R10 destination"}, VLEN'(res_dst_o), VLEN'(x.dst));
                  last_res = x.res;
               end else begin
                  chk(res_data_o == last_res, {x.tag, " R10 result held"}, res_data_o, last_res);
               end
               chk(exp_addr_q.size() == 0, {x.tag, " R4 all accesses made"},
                   VLEN'(exp_addr_q.size()), '0);
            end
         end
      end
   end

   task automatic run_cmd(input logic [31:0] insn, input logic [63:0] gpr, input logic [63:0] sp,
                          input logic [63:0] idx, input logic [PW-1:0] pred, input string tag,
                          input bit inject);
      exp_t        x;
      int          es, start_oc, cyc;
      bit          legal, any;
      logic [63:0] a0;
      es = 0;
      if (insn[31:23] == 9'b101001010) begin
         if (insn[22:21] == 2'b10 && insn[15:13] == 3'b010) es = 32;
         if (insn[22:21] == 2'b11 && insn[15:13] == 3'b010) es = 64;
         if (insn[22:21] == 2'b00 && insn[15:13] == 3'b100) es = 128;
      end
      legal = (es != 0) && (insn[20:16] != 5'd31);
      x.res = '0; x.dst = insn[4:0]; x.tag = tag;
      if (!legal) begin
         x.kind = 1;
      end else begin
         any = 1'b0;
         for (int e = 0; e < VLEN/es; e++) if (pred[e*es/8]) any = 1'b1;
         if (insn[9:5] == 5'd31 && sp[3:0] != 4'd0 && any) begin
            x.kind = 2;
         end else begin
            x.kind = 0;
            a0 = ((insn[9:5] == 5'd31) ? sp : gpr) + (idx << 2);
            for (int e = 0; e < VLEN/es; e++) begin
               if (pred[e*es/8]) begin
                  x.res[e*es +: 32] = dfun(a0 + 64'(4*e), mem_seed);
                  exp_addr_q.push_back(a0 + 64'(4*e));
               end
            end
         end
      end
      exp_q.push_back(x);
      @(negedge clk);
      cmd_insn_i = insn; cmd_gpr_i = gpr; cmd_sp_i = sp; cmd_index_i = idx; cmd_pred_i = pred;
      cmd_valid_i = 1'b1;
      start_oc = outcome_cnt;
      @(negedge clk);
      cmd_valid_i = 1'b0;
      cyc = 1;
      if (inject) begin
         @(negedge clk);
         chk(busy_o == 1'b1, "R12 busy during sequence", VLEN'(busy_o), VLEN'(1));
         cmd_insn_i = mk(32, 5'd31, 5'd2, 5'd9);
         cmd_valid_i = 1'b1;
         @(negedge clk);
         cmd_valid_i = 1'b0;
         cyc += 2;
      end
      while (outcome_cnt == start_oc) begin
         @(negedge clk);
         cyc++;
      end
      last_cycles = cyc;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int c1;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      chk({busy_o, mem_req_o, done_o, illegal_o, sp_fault_o} == 5'd0, "R10 reset outputs",
          VLEN'({busy_o, mem_req_o, done_o, illegal_o, sp_fault_o}), '0);
      chk(res_data_o == '0, "R10 reset result", res_data_o, '0);

      // R1 R6 R8: 32-bit elements, all active
      run_cmd(mk(32, 5'd4, 5'd2, 5'd7), 64'h0000_0000_0000_1000, 64'h0, 64'd5, '1, "R6 32b full", 0);
      // R5 R7: mixed predicate at 32-bit
      run_cmd(mk(32, 5'd4, 5'd2, 5'd11), 64'h0000_0040_0000_2000, 64'h0, 64'd3, 32'h0F0F_0101, "R5 32b mixed", 0);
      // R7: 64-bit, non-leading bits set in inactive group
      run_cmd(mk(64, 5'd1, 5'd3, 5'd12), 64'h0000_0000_0003_0000, 64'h0, 64'd2, 32'h0000_0F0E, "R7 64b group", 0);
      // R8: 128-bit, all ones -> two slots
      run_cmd(mk(128, 5'd1, 5'd3, 5'd13), 64'h0000_0000_0004_0010, 64'h0, 64'd0, '1, "R8 128b full", 0);
      // R3: wrap-around start and running address
      run_cmd(mk(32, 5'd6, 5'd8, 5'd1), 64'hFFFF_FFFF_FFFF_FFF8, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, '1, "R3 wrap", 0);
      // R3: stack-pointer base, aligned
      run_cmd(mk(64, 5'd6, 5'd31, 5'd2), 64'hDEAD_0000_0000_0000, 64'h0000_0000_8000_1000, 64'd1, '1, "R3 sp base", 0);
      // R11: misaligned stack pointer with active lanes
      run_cmd(mk(32, 5'd6, 5'd31, 5'd3), 64'h0, 64'h0000_0000_8000_1004, 64'd0, '1, "R11 sp misaligned", 0);
      // R11: misaligned, no active 64-bit lane although other bits are set
      run_cmd(mk(64, 5'd6, 5'd31, 5'd4), 64'h0, 64'h0000_0000_8000_1004, 64'd0, 32'h0E0E_0E0E, "R11 skip idle", 0);
      // R5: no active lanes, general base
      run_cmd(mk(32, 5'd6, 5'd0, 5'd5), 64'h0000_0000_0000_5000, 64'h0, 64'd9, '0, "R5 all inactive", 0);
      // R2: index field 31, bad prefix, bad class
      run_cmd(mk(32, 5'd31, 5'd0, 5'd6), 64'h1000, 64'h0, 64'd0, '1, "R2 index field 31", 0);
      run_cmd(32'h0000_0000, 64'h1000, 64'h0, 64'd0, '1, "R2 bad prefix", 0);
      run_cmd({9'b101001010, 2'b00, 5'd2, 3'b010, 3'd0, 5'd1, 5'd1}, 64'h1000, 64'h0, 64'd0, '1, "R1 bad class", 0);
      // R12: command injected while busy
      run_cmd(mk(32, 5'd2, 5'd1, 5'd8), 64'h0000_0000_0009_0000, 64'h0, 64'd7, '1, "R12 busy inject", 1);
      // R13: same predicate, different data
      mem_seed = 32'h0000_0000;
      run_cmd(mk(64, 5'd3, 5'd1, 5'd9), 64'h0000_0000_000A_0000, 64'h0, 64'd1, 32'h0100_0001, "R13 run a", 0);
      c1 = last_cycles;
      mem_seed = 32'hFFFF_FFFF;
      run_cmd(mk(64, 5'd3, 5'd1, 5'd9), 64'h0000_0000_000A_0000, 64'h0, 64'd1, 32'h0100_0001, "R13 run b", 0);
      chk(c1 == last_cycles, "R13 data-independent timing", VLEN'(last_cycles), VLEN'(c1));

      repeat (10) @(negedge clk);
      chk(exp_q.size() == 0, "R10 no outstanding outcome", VLEN'(exp_q.size()), '0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule